// File: doc/BRIEF.md
# Hex Record Tape Loader

This block takes a stream of text characters from a byte-wide receive interface and loads memory from it. The characters are hexadecimal load records of the S1/S9 kind. A load starts with a one-cycle pulse on `load_start`. The loader first sends a reader-on control code, then hunts for record starts. Each data record is checked against a one's-complement checksum, and its data bytes go out on a simple memory write port. The load ends with a reader-off control code, either when an end record arrives or when a record turns out to be malformed.

Every control code and the error marker leave through a single-character transmit port with a valid/ready handshake. The receive side is stalled for as long as a transmit is waiting. A `busy` flag covers the whole load. A saturating counter counts the loads that ended on a record error.

Top module: `hexrec_loader`

## Requirements
- R1: A `load_start` pulse while idle raises `busy` and queues the reader-on code 0x11 as the first transmitted character. A `load_start` pulse while `busy` is high has no effect: no second 0x11 is sent.
- R2: While hunting, every character other than 'S' (0x53) is discarded. After an 'S', a following '1' (0x31) opens a data record. Any other character is examined again as a possible 'S', so the sequences "SAS1" and "SS1" both open a record.
- R3: An 'S' followed by '9' (0x39) ends the load. The reader-off code 0x13 is transmitted, and `busy` falls on the clock edge that hands 0x13 over.
- R4: A data record consists of, in order, a count byte, the load address high byte, the load address low byte, (count − 3) data bytes and a checksum byte, each byte sent as two hex characters with the high nibble first. The data bytes are written to consecutive addresses starting at the load address, and the address wraps from 0xFFFF to 0x0000.
- R5: The hex digits 0-9, A-F and a-f are accepted. Bit 7 of every received character is cleared before any comparison.
- R6: A record whose count, address, data and checksum bytes sum to 0xFF modulo 256 is accepted, and hunting resumes within the same load, so several records may precede the end record.
- R7: A non-hex character inside a record, a count byte below 3, or a checksum sum other than 0xFF ends the load. The loader transmits '?' (0x3F) then 0x13, and `err_count` rises by one, saturating at its maximum.
- R8: `tx_valid` and `tx_char` hold steady until `tx_ready` is high at a clock edge. `rx_ready` stays low while any transmit is waiting.
- R9: After reset, `busy`, `tx_valid`, `rx_ready` and `mem_we` are low and `err_count` is zero.
- R10: `mem_we` is a single-cycle pulse, high in the cycle after the clock edge that accepts a data byte's second digit. The write happens before the record's checksum is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | One-cycle request to begin a load |
| rx_valid | input | 1 | Received character present |
| rx_char | input | 8 | Received character |
| rx_ready | output | 1 | Loader takes the character at this edge |
| tx_valid | output | 1 | Control or error character waiting to be sent |
| tx_char | output | 8 | Character to transmit |
| tx_ready | input | 1 | Transmitter accepts the character at this edge |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | A load is in progress |
| err_count | output | ERR_W | Saturating count of loads ended by a record error |

## Verification
All outputs come from registers. `mem_we`, `mem_addr` and `mem_wdata` therefore change on the same edge that accepts a data byte's second digit. A queued transmit character appears one edge after its cause, and `busy` falls on the edge that takes 0x13. The bench drives inputs and samples outputs at the falling edge. Each character is recorded at the falling edge just before the rising edge that accepts it, so every check refers to a known edge count. The strobe timing of R10 is checked in the first half-cycle after acceptance and again one cycle later.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int ADDR_W = 16;

    localparam logic [7:0] CH_REC    = 8'h53;
    localparam logic [7:0] CH_DATA   = 8'h31;
    localparam logic [7:0] CH_END    = 8'h39;
    localparam logic [7:0] CODE_ON   = 8'h11;
    localparam logic [7:0] CODE_OFF  = 8'h13;
    localparam logic [7:0] CODE_ERR  = 8'h3F;
    localparam logic [7:0] SUM_OK    = 8'hFF;
    localparam logic [7:0] MIN_COUNT = 8'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_TYPE,
        ST_FIELD,
        ST_DONE
    } ld_state_e;

    typedef enum logic [2:0] {
        FL_COUNT,
        FL_ADDR_HI,
        FL_ADDR_LO,
        FL_DATA,
        FL_CSUM
    } field_e;

endpackage

// File: rtl/hexrec_char_decode.sv
module hexrec_char_decode
    import hexrec_pkg::*;
(
    input  logic [7:0] raw,
    output logic       is_rec,
    output logic       is_data,
    output logic       is_end,
    output logic       is_hex,
    output logic [3:0] nib
);
    logic [7:0] c;

    always_comb begin
        c       = raw & 8'h7F;
        is_rec  = (c == CH_REC);
        is_data = (c == CH_DATA);
        is_end  = (c == CH_END);
        is_hex  = 1'b0;
        nib     = 4'h0;
        if (c >= 8'h30 && c <= 8'h39) begin
            is_hex = 1'b1;
            nib    = c[3:0];
        end else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
            is_hex = 1'b1;
            nib    = c[3:0] + 4'd9;
        end
    end

endmodule

// File: rtl/hexrec_tx_slot.sv
module hexrec_tx_slot
    import hexrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_char,
    input  logic       push_tail,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_char,
    output logic       drained
);
    typedef struct packed {
        logic       valid;
        logic [7:0] chr;
        logic       tail;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d  = slot_q;
        drained = 1'b0;
        if (slot_q.valid && tx_ready) begin
            if (slot_q.tail) begin
                slot_d.chr  = CODE_OFF;
                slot_d.tail = 1'b0;
            end else begin
                slot_d.valid = 1'b0;
                drained      = 1'b1;
            end
        end
        if (push) begin
            slot_d.valid = 1'b1;
            slot_d.chr   = push_char;
            slot_d.tail  = push_tail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign tx_valid = slot_q.valid;
    assign tx_char  = slot_q.chr;

    // R8: a waiting character is held until taken
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_char)));

    // R7: the error marker is always followed by reader-off
    a_r7_off_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_char == CODE_ERR) |=> (tx_valid && tx_char == CODE_OFF));

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_char,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_char,
    input  logic              tx_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic [ERR_W-1:0]  err_count
);
    typedef struct packed {
        ld_state_e         st;
        field_e            fld;
        logic              have_hi;
        logic [3:0]        hi;
        logic [7:0]        remain;
        logic [7:0]        sum;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
        logic [ERR_W-1:0]  errs;
    } ld_t;

    ld_t ld_d, ld_q;

    logic       is_rec, is_data, is_end, is_hex;
    logic [3:0] nib;
    logic       push, push_tail, drained;
    logic [7:0] push_char;
    logic       rx_fire, err_hit;
    logic [7:0] byte_val, sum_next;

    hexrec_char_decode dec_i (
        .raw     (rx_char),
        .is_rec  (is_rec),
        .is_data (is_data),
        .is_end  (is_end),
        .is_hex  (is_hex),
        .nib     (nib)
    );

    hexrec_tx_slot tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_char (push_char),
        .push_tail (push_tail),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_char   (tx_char),
        .drained   (drained)
    );

    assign rx_ready = !tx_valid &&
                      (ld_q.st == ST_HUNT || ld_q.st == ST_TYPE || ld_q.st == ST_FIELD);
    assign rx_fire  = rx_valid && rx_ready;
    assign byte_val = {ld_q.hi, nib};
    assign sum_next = ld_q.sum + byte_val;

    always_comb begin
        ld_d      = ld_q;
        ld_d.we   = 1'b0;
        push      = 1'b0;
        push_char = CODE_ON;
        push_tail = 1'b0;
        err_hit   = 1'b0;

        unique case (ld_q.st)
            ST_IDLE: begin
                if (load_start) begin
                    push      = 1'b1;
                    push_char = CODE_ON;
                    ld_d.st   = ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (rx_fire && is_rec) ld_d.st = ST_TYPE;
            end
            ST_TYPE: begin
                if (rx_fire) begin
                    if (is_data) begin
                        ld_d.st      = ST_FIELD;
                        ld_d.fld     = FL_COUNT;
                        ld_d.have_hi = 1'b0;
                    end else if (is_end) begin
                        push      = 1'b1;
                        push_char = CODE_OFF;
                        ld_d.st   = ST_DONE;
                    end else if (!is_rec) begin
                        ld_d.st = ST_HUNT;
                    end
                end
            end
            ST_FIELD: begin
                if (rx_fire) begin
                    if (!is_hex) begin
                        err_hit = 1'b1;
                    end else if (!ld_q.have_hi) begin
                        ld_d.have_hi = 1'b1;
                        ld_d.hi      = nib;
                    end else begin
                        ld_d.have_hi = 1'b0;
                        ld_d.sum     = sum_next;
                        unique case (ld_q.fld)
                            FL_COUNT: begin
                                ld_d.remain = byte_val;
                                ld_d.sum    = byte_val;
                                if (byte_val < MIN_COUNT) err_hit = 1'b1;
                                else                      ld_d.fld = FL_ADDR_HI;
                            end
                            FL_ADDR_HI: begin
                                ld_d.addr = {byte_val, ld_q.addr[7:0]};
                                ld_d.fld  = FL_ADDR_LO;
                            end
                            FL_ADDR_LO: begin
                                ld_d.addr   = {ld_q.addr[ADDR_W-1:8], byte_val};
                                ld_d.remain = ld_q.remain - MIN_COUNT;
                                ld_d.fld    = (ld_q.remain == MIN_COUNT) ? FL_CSUM : FL_DATA;
                            end
                            FL_DATA: begin
                                ld_d.we     = 1'b1;
                                ld_d.waddr  = ld_q.addr;
                                ld_d.wdata  = byte_val;
                                ld_d.addr   = ld_q.addr + 1'b1;
                                ld_d.remain = ld_q.remain - 8'd1;
                                if (ld_q.remain == 8'd1) ld_d.fld = FL_CSUM;
                            end
                            FL_CSUM: begin
                                if (sum_next == SUM_OK) ld_d.st = ST_HUNT;
                                else                    err_hit = 1'b1;
                            end
                            default: err_hit = 1'b1;
                        endcase
                    end
                end
            end
            ST_DONE: begin
                if (drained) ld_d.st = ST_IDLE;
            end
            default: ld_d.st = ST_IDLE;
        endcase

        if (err_hit) begin
            push      = 1'b1;
            push_char = CODE_ERR;
            push_tail = 1'b1;
            ld_d.st   = ST_DONE;
            if (ld_q.errs != '1) ld_d.errs = ld_q.errs + ERR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q     <= '0;
            ld_q.st  <= ST_IDLE;
            ld_q.fld <= FL_COUNT;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign mem_we    = ld_q.we;
    assign mem_addr  = ld_q.waddr;
    assign mem_wdata = ld_q.wdata;
    assign busy      = (ld_q.st != ST_IDLE);
    assign err_count = ld_q.errs;

    // R1: a load always opens with reader-on
    a_r1_on_code_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_valid && tx_char == CODE_ON));

    // R9: nothing is sent or written outside a load
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !mem_we));

    // R10: the write strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: data writes never coincide with a waiting transmit
    a_r4_write_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !tx_valid);

    // R7: the error count moves by one and only alongside the error marker
    a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |->
            ((err_count == $past(err_count) + ERR_W'(1)) && tx_valid && tx_char == CODE_ERR));

endmodule

// File: tb/hexrec_loader_tb_top.sv
`timescale 1ns/1ps
module hexrec_loader_tb_top;
    import hexrec_pkg::*;

    localparam int TB_ERR_W = 2;
    localparam int TXT_B    = 40;
    localparam int NVEC     = 8;

    typedef struct packed {
        logic [8*TXT_B-1:0] txt;
        logic [7:0]         nw;
        logic [15:0]        fa;
        logic [7:0]         fd;
        logic [15:0]        la;
        logic [7:0]         ld;
        logic               bad;
    } vec_t;

    // text, writes, first addr/data, last addr/data, ends in error
    localparam vec_t VECS [NVEC] = '{
        '{"S1050100AABB94S9",             8'd2, 16'h0100, 8'hAA, 16'h0101, 8'hBB, 1'b0},
        '{"zSASS1050100aabb94S9",         8'd2, 16'h0100, 8'hAA, 16'h0101, 8'hBB, 1'b0},
        '{"S105FFFF1234B6S9",             8'd2, 16'hFFFF, 8'h12, 16'h0000, 8'h34, 1'b0},
        '{"S10400107E6DS1050100AABB94S9", 8'd3, 16'h0010, 8'h7E, 16'h0101, 8'hBB, 1'b0},
        '{"S1030200FAS9",                 8'd0, 16'h0000, 8'h00, 16'h0000, 8'h00, 1'b0},
        '{"S1050100AABB95",               8'd2, 16'h0100, 8'hAA, 16'h0101, 8'hBB, 1'b1},
        '{"S1050G",                       8'd0, 16'h0000, 8'h00, 16'h0000, 8'h00, 1'b1},
        '{"S102",                         8'd0, 16'h0000, 8'h00, 16'h0000, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_start = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic rx_ready;
    logic tx_valid;
    logic [7:0] tx_char;
    logic tx_ready = 1'b0;
    logic mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic busy;
    logic [TB_ERR_W-1:0] err_count;

    always #4 clk = ~clk;

    hexrec_loader #(.ERR_W(TB_ERR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_start(load_start),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .err_count(err_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_err = 0;
    int cyc = 0;

    logic [7:0]  tx_log [16];
    int          tx_n = 0;
    logic [15:0] wa_log [64];
    logic [7:0]  wd_log [64];
    int          wr_n = 0;
    logic        hold_tx = 1'b0;
    int          pat = 0;

    // transmit acceptor and loggers, all at the falling edge
    always @(negedge clk) begin
        logic rdy;
        pat = pat + 1;
        rdy = !hold_tx && (pat % 3 != 0);
        tx_ready = rdy;
        if (tx_valid && rdy && tx_n < 16) begin
            tx_log[tx_n] = tx_char;
            tx_n = tx_n + 1;
        end
        if (mem_we && wr_n < 64) begin
            wa_log[wr_n] = mem_addr;
            wd_log[wr_n] = mem_wdata;
            wr_n = wr_n + 1;
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] c);
        logic acc;
        rx_valid = 1'b1;
        rx_char  = c;
        do begin
            acc = rx_ready;
            @(negedge clk);
        end while (!acc);
        rx_valid = 1'b0;
    endtask

    task automatic send_text(input logic [8*TXT_B-1:0] t, input bit set7);
        for (int i = TXT_B - 1; i >= 0; i--) begin
            logic [7:0] c;
            c = t[i*8 +: 8];
            if (c != 8'h00) send_char(set7 ? (c | 8'h80) : c);
        end
    endtask

    task automatic clear_logs;
        tx_n = 0;
        wr_n = 0;
    endtask

    task automatic pulse_start;
        load_start = 1'b1;
        tick();
        load_start = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy) tick();
        tick();
    endtask

    task automatic check_tx(input string req, input bit bad);
        chk(req, "tx count", tx_n, bad ? 3 : 2);
        chk("R1", "first tx code", tx_log[0], CODE_ON);
        if (bad) begin
            chk("R7", "error marker", tx_log[1], CODE_ERR);
            chk("R7", "reader-off after error", tx_log[2], CODE_OFF);
        end else begin
            chk("R3", "reader-off code", tx_log[1], CODE_OFF);
        end
        chk("R3", "busy low after load", busy, 0);
    endtask

    task automatic run_vec(input vec_t v, input bit set7, input string req);
        clear_logs();
        pulse_start();
        send_text(v.txt, set7);
        wait_idle();
        check_tx(req, v.bad);
        chk("R4", "write count", wr_n, v.nw);
        if (v.nw != 0) begin
            chk("R4", "first write addr", wa_log[0], v.fa);
            chk("R4", "first write data", wd_log[0], v.fd);
            chk("R4", "last write addr", wa_log[wr_n-1], v.la);
            chk("R4", "last write data", wd_log[wr_n-1], v.ld);
        end
        if (v.bad && exp_err < 3) exp_err = exp_err + 1;
        chk("R7", "error count", err_count, exp_err);
    endtask

    initial begin
        repeat (5) tick();
        rst_n = 1'b1;

        // R9: reset state
        chk("R9", "busy", busy, 0);
        chk("R9", "tx_valid", tx_valid, 0);
        chk("R9", "rx_ready", rx_ready, 0);
        chk("R9", "mem_we", mem_we, 0);
        chk("R9", "err_count", err_count, 0);
        tick();

        // table walk: R2 R4 R5 R6 R7 cases
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VECS[v], 1'b0, (v == 1) ? "R2" : ((v == 3) ? "R6" : "R4"));
        end

        // R7: error counter saturates
        run_vec('{"S1X", 8'd0, 16'h0, 8'h0, 16'h0, 8'h0, 1'b1}, 1'b0, "R7");
        chk("R7", "count saturated", err_count, 3);

        // R5: bit 7 set on every character
        run_vec(VECS[0], 1'b1, "R5");

        // R8: transmit held while not ready, receive stalled
        clear_logs();
        hold_tx = 1'b1;
        tick();
        pulse_start();
        rx_char = CH_REC;
        rx_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R8", "tx_valid held", tx_valid, 1);
            chk("R8", "tx_char held", tx_char, CODE_ON);
            chk("R8", "rx stalled", rx_ready, 0);
            tick();
        end
        rx_valid = 1'b0;
        hold_tx = 1'b0;
        repeat (4) tick();
        // R1: second start while busy ignored
        pulse_start();
        send_text("S9", 1'b0);
        wait_idle();
        check_tx("R1", 1'b0);

        // R10: write strobe timing
        clear_logs();
        pulse_start();
        send_text("S10402005", 1'b0);
        send_char("A");
        chk("R10", "strobe after second digit", mem_we, 1);
        chk("R10", "write addr", mem_addr, 16'h0200);
        chk("R10", "write data", mem_wdata, 8'h5A);
        tick();
        chk("R10", "strobe one cycle", mem_we, 0);
        send_text("9FS9", 1'b0);
        wait_idle();
        check_tx("R10", 1'b0);

        summary();
        $finish;
    end

endmodule